// File: doc/BRIEF.md
# Clock Failure Detector with Failover

This block supervises a high-speed external oscillator clock. Its counting logic runs on the always-running internal oscillator. Software turns monitoring on. The watch only starts once the oscillator reports that it has settled. While the block is watching, every rising edge of the external clock flips a toggle flop. That toggle is synchronized into the reference domain. If a fixed number of reference cycles pass with no change of the synchronized toggle, the external clock is declared dead.

On a failure the block does four things:
- It commands the oscillator off.
- It also commands the PLL off if the PLL takes its input from the external clock and is the current system clock.
- It overrides the system clock selection with the internal oscillator, but only if the dead clock was feeding the system.
- It raises a sticky non-maskable interrupt flag and a single-cycle timer break event.

The tripped condition holds until software drops the monitoring enable. The interrupt flag holds until software writes one to clear it.

The control is a four-state machine:
- `CF_IDLE`: monitoring is off.
- `CF_WAIT`: monitoring is enabled, and the block waits for the oscillator to report ready.
- `CF_WATCH`: the quiet window is being timed.
- `CF_TRIP`: a failure has been taken.

Its transitions are:
- ENABLE (`CF_IDLE`→`CF_WAIT`, when the enable is high).
- ARM (`CF_WAIT`→`CF_WATCH`, when ready is high).
- UNREADY (`CF_WATCH`→`CF_WAIT`, when ready falls).
- FAIL (`CF_WATCH`→`CF_TRIP`, when the window expires).
- DISABLE (any state other than `CF_IDLE`→`CF_IDLE`, when the enable is low).

DISABLE has priority over every other transition.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset, `osc_off`, `pll_off`, `nmi_req` and `brk_evt` are low, and `sel_out` equals `sys_sel`.
- R2: No failure is taken while `mon_en` is low or `osc_ready` is low, even if the external clock is stopped.
- R3: While armed, once QUIET_WIN consecutive reference cycles pass with no synchronized external toggle, the block trips. From the next cycle, `osc_off` is high.
- R4: A low `osc_ready` while armed disarms the detector. When ready returns, the quiet window restarts from zero.
- R5: At a failure, `pll_off` is raised only if `sys_sel` is PLL (2'b10) and `pll_from_ext` is high.
- R6: `sys_sel` encodes 2'b00 internal, 2'b01 external, 2'b10 PLL (2'b11 is passed through). After a failure on a clock that feeds the system, `sel_out` is forced to 2'b00. Such a clock is 2'b01, or 2'b10 with `pll_from_ext` high. In every other case `sel_out` equals `sys_sel`.
- R7: `nmi_req` sets on a failure and stays set until `flag_clr` is high. A failure in the same cycle wins over the clear.
- R8: `brk_evt` is high for exactly one cycle per failure, in the same cycle `osc_off` first rises.
- R9: The tripped outputs hold while `mon_en` stays high. Dropping `mon_en` releases them on the next cycle. Raising it again re-arms the detector.
- R10: A running external clock never causes a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal oscillator clock; clocks all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Supervised external oscillator clock |
| mon_en | input | 1 | Software monitoring enable |
| osc_ready | input | 1 | External oscillator settled indication |
| sys_sel | input | 2 | Current system clock selection (00 int, 01 ext, 10 PLL) |
| pll_from_ext | input | 1 | PLL reference is the external clock (divided or not) |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| osc_off | output | 1 | Oscillator disable command |
| pll_off | output | 1 | PLL disable command |
| sel_out | output | 2 | Selection to drive the system clock mux |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |
| brk_evt | output | 1 | One-cycle break event for the timers |

## Verification
The external clock is applied in four patterns:
- Running continuously while the detector is armed. This shows that real activity never trips it.
- Stopped while monitoring is off or the oscillator is unready. This separates arming from detection.
- Stopped while armed. This fixes the exact trip cycle against the quiet window.
- Stopped with a ready drop part-way through the window. This shows that the window restarts rather than accumulating.

Each stop is repeated with the system running on the external clock, on the PLL fed from the external clock, and on the PLL fed internally. This tells a failover apart from a disable-only failure, and shows when the PLL is shut down.

A behavioural model in the bench predicts every output on every reference cycle. The bench compares the design against it.

// File: rtl/cfd_pkg.sv
`timescale 1ns/100ps
package cfd_pkg;
    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_WAIT  = 2'd1,
        CF_WATCH = 2'd2,
        CF_TRIP  = 2'd3
    } cf_state_e;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PLL = 2'b10
    } clk_src_e;
endpackage

// File: rtl/cfd_edge_sync.sv
`timescale 1ns/100ps
module cfd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ext_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic seen
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic              tog;
    logic [PIPE_W-1:0] pipe;

    // one flip per external rising edge
    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    // synchronizer stages plus one history stage for change detection
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[PIPE_W-2:0], tog};
    end

    assign seen = pipe[PIPE_W-1] ^ pipe[PIPE_W-2];
endmodule

// File: rtl/cfd_quiet_timer.sv
`timescale 1ns/100ps
module cfd_quiet_timer #(
    parameter int QUIET_WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic seen,
    output logic expired
);
    localparam int CNT_W = (QUIET_WIN > 2) ? $clog2(QUIET_WIN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET_WIN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!arm || seen)    cnt <= '0;
        else if (cnt != LAST)     cnt <= cnt + 1'b1;
    end

    assign expired = arm && !seen && (cnt == LAST);

    AST_QUIET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arm) |-> (cnt == '0));  // R4
endmodule

// File: rtl/cfd_ctrl_fsm.sv
`timescale 1ns/100ps
module cfd_ctrl_fsm
    import cfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mon_en,
    input  logic       osc_ready,
    input  logic       expired,
    input  logic [1:0] sys_sel,
    input  logic       pll_from_ext,
    input  logic       flag_clr,
    output logic       arm,
    output logic       osc_off,
    output logic       pll_off,
    output logic       force_int,
    output logic       nmi_req,
    output logic       brk_evt
);
    cf_state_e state, state_nx;
    logic      trip_evt;
    logic      pll_lat, force_lat, nmi_q, brk_q;
    logic      pll_feeds, ext_feeds;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CF_IDLE;
        else        state <= state_nx;
    end

    // next state: DISABLE has priority over all other transitions
    always_comb begin
        state_nx = state;
        trip_evt = 1'b0;
        unique case (state)
            CF_IDLE:  if (mon_en) state_nx = CF_WAIT;
            CF_WAIT: begin
                if (!mon_en)        state_nx = CF_IDLE;
                else if (osc_ready) state_nx = CF_WATCH;
            end
            CF_WATCH: begin
                if (!mon_en)         state_nx = CF_IDLE;
                else if (!osc_ready) state_nx = CF_WAIT;
                else if (expired) begin
                    state_nx = CF_TRIP;
                    trip_evt = 1'b1;
                end
            end
            CF_TRIP:  if (!mon_en) state_nx = CF_IDLE;
            default:  state_nx = CF_IDLE;
        endcase
    end

    assign pll_feeds = (sys_sel == SRC_PLL) && pll_from_ext;
    assign ext_feeds = (sys_sel == SRC_EXT) || pll_feeds;

    // captured consequences of the failure and the event flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_lat   <= 1'b0;
            force_lat <= 1'b0;
            nmi_q     <= 1'b0;
            brk_q     <= 1'b0;
        end else begin
            if (trip_evt) begin
                pll_lat   <= pll_feeds;
                force_lat <= ext_feeds;
            end
            brk_q <= trip_evt;
            if (trip_evt)      nmi_q <= 1'b1;
            else if (flag_clr) nmi_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        arm       = (state == CF_WATCH);
        osc_off   = (state == CF_TRIP);
        pll_off   = (state == CF_TRIP) && pll_lat;
        force_int = (state == CF_TRIP) && force_lat;
        nmi_req   = nmi_q;
        brk_evt   = brk_q;
    end

    AST_TRIP_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_off) |-> $past(mon_en && osc_ready));  // R2
    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> !brk_evt);  // R8
    AST_BRK_WITH_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |-> (osc_off && nmi_req));  // R3
    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !flag_clr) |=> nmi_req);  // R7
    AST_PLL_WITH_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |-> osc_off);  // R5
    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && mon_en) |=> osc_off);  // R9
endmodule

// File: rtl/clk_fail_guard.sv
`timescale 1ns/100ps
module clk_fail_guard
    import cfd_pkg::*;
#(
    parameter int QUIET_WIN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       ext_clk,
    input  logic       mon_en,
    input  logic       osc_ready,
    input  logic [1:0] sys_sel,
    input  logic       pll_from_ext,
    input  logic       flag_clr,
    output logic       osc_off,
    output logic       pll_off,
    output logic [1:0] sel_out,
    output logic       nmi_req,
    output logic       brk_evt
);
    logic seen, arm, expired, force_int;

    cfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ext_clk (ext_clk),
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .seen    (seen)
    );

    cfd_quiet_timer #(.QUIET_WIN(QUIET_WIN)) u_timer (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .seen    (seen),
        .expired (expired)
    );

    cfd_ctrl_fsm u_fsm (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .mon_en       (mon_en),
        .osc_ready    (osc_ready),
        .expired      (expired),
        .sys_sel      (sys_sel),
        .pll_from_ext (pll_from_ext),
        .flag_clr     (flag_clr),
        .arm          (arm),
        .osc_off      (osc_off),
        .pll_off      (pll_off),
        .force_int    (force_int),
        .nmi_req      (nmi_req),
        .brk_evt      (brk_evt)
    );

    assign sel_out = force_int ? SRC_INT : sys_sel;

    AST_PLL_OFF_FAILS_OVER: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pll_off |-> (sel_out == SRC_INT));  // R6
    AST_IDLE_PASSES_SEL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !osc_off |-> (sel_out == sys_sel));  // R6
endmodule

// File: tb/test_clk_fail_guard.sv
`timescale 1ns/100ps
module test_clk_fail_guard;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ext_run = 1'b0;
    logic       mon_en = 1'b0;
    logic       osc_ready = 1'b0;
    logic [1:0] sys_sel = 2'b00;
    logic       pll_from_ext = 1'b0;
    logic       flag_clr = 1'b0;
    logic       osc_off, pll_off, nmi_req, brk_evt;
    logic [1:0] sel_out;

    int nvec = 0;
    int nbad = 0;
    int ext_edges = 0;
    int brk_count = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // external clock on a grid that never meets a reference edge
    initial begin
        #0.3;
        forever begin
            #9.5;
            if (ext_run) ext_clk = ~ext_clk;
        end
    end
    always @(posedge ext_clk) ext_edges++;

    clk_fail_guard #(.QUIET_WIN(WIN)) i_clk_fail_guard (
        .ref_clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .mon_en(mon_en),
        .osc_ready(osc_ready), .sys_sel(sys_sel), .pll_from_ext(pll_from_ext),
        .flag_clr(flag_clr), .osc_off(osc_off), .pll_off(pll_off),
        .sel_out(sel_out), .nmi_req(nmi_req), .brk_evt(brk_evt)
    );

    // behavioural reference model
    int  m_mode;  // 0 off, 1 waiting, 2 watching, 3 tripped
    int  m_quiet;
    bit  h1, h2, h3;
    bit  m_force, m_pll, m_nmi, m_brk;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_quiet = 0; h1 = 0; h2 = 0; h3 = 0;
            m_force = 0; m_pll = 0; m_nmi = 0; m_brk = 0;
        end else begin
            bit seen_now, fail;
            seen_now = h2 ^ h3;
            h3 = h2; h2 = h1; h1 = ext_edges[0];
            fail = 0;
            if (m_mode != 0 && !mon_en) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                m_mode = 1;
            end else if (m_mode == 1) begin
                if (osc_ready) begin m_mode = 2; m_quiet = 0; end
            end else if (m_mode == 2) begin
                if (!osc_ready) m_mode = 1;
                else if (seen_now) m_quiet = 0;
                else if (m_quiet == WIN - 1) fail = 1;
                else m_quiet++;
                if (fail) begin
                    m_mode  = 3;
                    m_pll   = (sys_sel == 2'b10) && pll_from_ext;
                    m_force = (sys_sel == 2'b01) || m_pll;
                end
            end
            m_brk = fail;
            if (fail) m_nmi = 1;
            else if (flag_clr) m_nmi = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_off;
            logic [1:0] e_sel;
            e_off = (m_mode == 3);
            e_sel = (e_off && m_force) ? 2'b00 : sys_sel;
            if (brk_evt) brk_count++;
            chk(osc_off == e_off, "R3", "osc_off", osc_off, e_off);
            chk(pll_off == (e_off && m_pll), "R5", "pll_off", pll_off, e_off && m_pll);
            chk(sel_out == e_sel, "R6", "sel_out", sel_out, e_sel);
            chk(nmi_req == m_nmi, "R7", "nmi_req", nmi_req, m_nmi);
            chk(brk_evt == m_brk, "R8", "brk_evt", brk_evt, m_brk);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic arm_watch();
        ext_run = 1; mon_en = 1; osc_ready = 1;
        step(40);
    endtask

    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        report();
    end

    initial begin
        sys_sel = 2'b01;
        step(4);
        #1; rst_n = 1;
        step(1);
        // R1 reset state
        chk(!osc_off && !pll_off && !nmi_req && !brk_evt, "R1", "outputs idle", osc_off, 0);
        chk(sel_out == 2'b01, "R1", "sel follows", sel_out, 1);

        // R2: enabled but oscillator unready, external clock silent
        mon_en = 1;
        step(40);
        chk(osc_off == 0, "R2", "no trip while unready", osc_off, 0);
        chk(nmi_req == 0, "R2", "no nmi while unready", nmi_req, 0);

        // R10: running clock while armed
        arm_watch();
        step(40);
        chk(osc_off == 0, "R10", "running clock no trip", osc_off, 0);

        // R3, R6, R8: direct external system clock fails
        brk_count = 0;
        ext_run = 0;
        step(40);
        chk(osc_off == 1, "R3", "trip after quiet window", osc_off, 1);
        chk(sel_out == 2'b00, "R6", "forced to internal", sel_out, 0);
        chk(pll_off == 0, "R5", "pll kept on", pll_off, 0);
        chk(brk_count == 1, "R8", "single break pulse", brk_count, 1);

        // R7: flag stays until cleared
        step(10);
        chk(nmi_req == 1, "R7", "nmi sticky", nmi_req, 1);
        flag_clr = 1; step(1); flag_clr = 0; step(1);
        chk(nmi_req == 0, "R7", "nmi cleared", nmi_req, 0);

        // R9: trip holds, released by disable
        chk(osc_off == 1, "R9", "trip held", osc_off, 1);
        mon_en = 0; step(1);
        chk(osc_off == 0 && sel_out == 2'b01, "R9", "released", osc_off, 0);

        // R5: PLL fed by external clock is system clock
        sys_sel = 2'b10; pll_from_ext = 1;
        arm_watch();
        chk(osc_off == 0, "R9", "re-armed without trip", osc_off, 0);
        ext_run = 0;
        step(40);
        chk(pll_off == 1, "R5", "pll disabled", pll_off, 1);
        chk(sel_out == 2'b00, "R6", "pll path forced", sel_out, 0);
        mon_en = 0; flag_clr = 1; step(1); flag_clr = 0;

        // R6: PLL on internal source -> no failover
        pll_from_ext = 0;
        arm_watch();
        ext_run = 0;
        step(40);
        chk(osc_off == 1 && nmi_req == 1, "R3", "disable-only trip", osc_off, 1);
        chk(sel_out == 2'b10, "R6", "selection untouched", sel_out, 2);
        chk(pll_off == 0, "R5", "internal pll kept", pll_off, 0);
        mon_en = 0; flag_clr = 1; step(1); flag_clr = 0;

        // R4: ready drop restarts the window
        sys_sel = 2'b01;
        arm_watch();
        ext_run = 0;
        step(10);
        osc_ready = 0; step(3); osc_ready = 1;
        step(10);
        chk(osc_off == 0, "R4", "window restarted", osc_off, 0);
        step(30);
        chk(osc_off == 1, "R4", "trip after restart", osc_off, 1);
        step(5);
        report();
    end
endmodule